// File: doc/BRIEF.md
# Flow-Exclusive Virtual Channel Allocator

This block picks the downstream virtual channel (VC) for flits leaving one router output port. Its rule is that flits of one flow never occupy more than one downstream VC at the same time. Because of that rule, a flow's packets stay in order, and VC choice can still be dynamic whenever a flow has fully drained.

Each cycle at most one flit asks for a VC. The request carries the flit's flow number and says whether the flit opens a packet. The block answers in the same cycle with either a granted VC or a stall. A per-flow table holds two values for each flow: the VC the flow is tied to and the number of its flits still sitting downstream. Grants raise that number. Credits that come back from the next router carry the flow number of the flit that departed, and they lower it. When the number reaches zero, the flow is free to move to any VC. Free VCs are chosen by a rotating pointer, so new bindings spread across the channels.

Top module: `vcx_alloc_top`

## Requirements
- R1: After reset every flow has a flit count of zero and a stored VC of 0, and the rotating pointer is at VC 0. The first packet-opening request with all VCs available is therefore granted VC 0.
- R2: A packet-opening request from a flow with count zero is granted the first available VC, searching upward from the rotating pointer and wrapping past the highest VC to VC 0. After such a fresh grant the pointer moves to one above the granted VC, wrapping the same way.
- R3: A packet-opening request from a flow with count zero stalls when no VC is available. The pointer does not move.
- R4: A packet-opening request from a flow with a nonzero count is granted the flow's stored VC when that VC is available, even if the pointer would choose another VC.
- R5: A request from a flow with a nonzero count stalls when its stored VC is unavailable, even if other VCs are available.
- R6: A request that does not open a packet always uses the flow's stored VC, whatever the count. It is granted when that VC is available and stalls when it is not.
- R7: Each granted flit adds one to its flow's count, and each returned credit subtracts one from the count of the flow it names. Once the count is back to zero, the next packet-opening request from that flow is allocated afresh as in R2.
- R8: When a grant and a credit hit the same flow in the same cycle, that flow's count does not change.
- R9: With no request there is neither a grant nor a stall. Grant and stall are never both high, and a grant only names an available VC.
- R10: No flow's count ever goes above the VC depth (VC_DEPTH).
- R11: A credit changes only the count of the flow it names. The counts of all other flows stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A flit is requesting a downstream VC this cycle |
| req_head | input | 1 | The requesting flit opens a packet |
| req_flow | input | FLOW_W | Flow number of the requesting flit |
| vc_avail | input | NUM_VC | One bit per downstream VC; high when that VC can accept a flit |
| cred_valid | input | 1 | A credit is returned this cycle |
| cred_flow | input | FLOW_W | Flow number of the flit that left the downstream VC |
| grant_valid | output | 1 | The request is granted this cycle |
| grant_vc | output | VC_W | The granted VC; meaningful only while grant_valid is high |
| req_stall | output | 1 | The request is refused this cycle and must retry |

## Verification
The assertions rely on two properties of the inputs. First, a credit never names a flow whose count is already zero. Second, a VC shows as available only while it has room, so no flow can be pushed past the VC depth. The stimulus sends credits only for flows it has previously been granted, and it counts its own grants against credits to stay within that limit. When it fills one flow to exactly the VC depth, it then removes that VC's availability bit before making any further request from that flow.

// File: rtl/vcx_pkg.sv
package vcx_pkg;

    localparam int DEF_NUM_VC    = 4;
    localparam int DEF_VC_DEPTH  = 8;
    localparam int DEF_NUM_FLOWS = 16;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_INC  = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_op_e;

    function automatic cnt_op_e cnt_op(input logic inc, input logic dec);
        if (inc && !dec) return CNT_INC;
        if (dec && !inc) return CNT_DEC;
        return CNT_HOLD;
    endfunction

endpackage

// File: rtl/vcx_rr_pick.sv
module vcx_rr_pick #(
    parameter int NUM_VC = vcx_pkg::DEF_NUM_VC,
    localparam int VC_W  = (NUM_VC > 1) ? $clog2(NUM_VC) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_VC-1:0] avail,
    input  logic              advance,
    output logic              pick_valid,
    output logic [VC_W-1:0]   pick_vc
);

    logic [VC_W-1:0] ptr_q;

    always_comb begin
        pick_valid = 1'b0;
        pick_vc    = '0;
        for (int off = NUM_VC - 1; off >= 0; off--) begin
            int idx;
            idx = (int'(ptr_q) + off) % NUM_VC;
            if (avail[idx]) begin
                pick_valid = 1'b1;
                pick_vc    = VC_W'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (advance && pick_valid) begin
            ptr_q <= VC_W'((int'(pick_vc) + 1) % NUM_VC);
        end
    end

    // R2: the picked VC is always one of the available ones
    assert_pick_avail_R2: assert property (@(posedge clk) disable iff (rst)
        pick_valid |-> avail[pick_vc]);

    // R3: nothing is picked when no VC is available
    assert_pick_none_R3: assert property (@(posedge clk) disable iff (rst)
        (avail == '0) |-> !pick_valid);

endmodule

// File: rtl/vcx_flow_table.sv
module vcx_flow_table #(
    parameter int NUM_FLOWS = vcx_pkg::DEF_NUM_FLOWS,
    parameter int NUM_VC    = vcx_pkg::DEF_NUM_VC,
    parameter int VC_DEPTH  = vcx_pkg::DEF_VC_DEPTH,
    localparam int FLOW_W   = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1,
    localparam int VC_W     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int CNT_W    = $clog2(VC_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [FLOW_W-1:0] rd_flow,
    output logic [VC_W-1:0]   rd_vc,
    output logic [CNT_W-1:0]  rd_cnt,
    input  logic              inc_en,
    input  logic [FLOW_W-1:0] inc_flow,
    input  logic              bind_en,
    input  logic [VC_W-1:0]   bind_vc,
    input  logic              dec_en,
    input  logic [FLOW_W-1:0] dec_flow
);
    import vcx_pkg::*;

    logic [VC_W-1:0]  vc_q  [NUM_FLOWS];
    logic [CNT_W-1:0] cnt_q [NUM_FLOWS];

    assign rd_vc  = vc_q[rd_flow];
    assign rd_cnt = cnt_q[rd_flow];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int f = 0; f < NUM_FLOWS; f++) begin
                vc_q[f]  <= '0;
                cnt_q[f] <= '0;
            end
        end else begin
            for (int f = 0; f < NUM_FLOWS; f++) begin
                if (bind_en && inc_flow == FLOW_W'(f)) begin
                    vc_q[f] <= bind_vc;
                end
                case (cnt_op(inc_en && inc_flow == FLOW_W'(f),
                             dec_en && dec_flow == FLOW_W'(f)))
                    CNT_INC: cnt_q[f] <= cnt_q[f] + 1'b1;
                    CNT_DEC: cnt_q[f] <= cnt_q[f] - 1'b1;
                    default: cnt_q[f] <= cnt_q[f];
                endcase
            end
        end
    end

    for (genvar g = 0; g < NUM_FLOWS; g++) begin : g_chk
        // R10: a flow never holds more flits downstream than one VC can store
        assert_cnt_depth_R10: assert property (@(posedge clk) disable iff (rst)
            cnt_q[g] <= CNT_W'(VC_DEPTH));

        // R7: credits only come back for flows that have flits outstanding
        assert_credit_owed_R7: assert property (@(posedge clk) disable iff (rst)
            (dec_en && dec_flow == FLOW_W'(g) && !(inc_en && inc_flow == FLOW_W'(g)))
            |-> cnt_q[g] != '0);
    end

endmodule

// File: rtl/vcx_alloc_top.sv
module vcx_alloc_top #(
    parameter int NUM_FLOWS = vcx_pkg::DEF_NUM_FLOWS,
    parameter int NUM_VC    = vcx_pkg::DEF_NUM_VC,
    parameter int VC_DEPTH  = vcx_pkg::DEF_VC_DEPTH,
    localparam int FLOW_W   = (NUM_FLOWS > 1) ? $clog2(NUM_FLOWS) : 1,
    localparam int VC_W     = (NUM_VC > 1) ? $clog2(NUM_VC) : 1,
    localparam int CNT_W    = $clog2(VC_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_head,
    input  logic [FLOW_W-1:0] req_flow,
    input  logic [NUM_VC-1:0] vc_avail,
    input  logic              cred_valid,
    input  logic [FLOW_W-1:0] cred_flow,
    output logic              grant_valid,
    output logic [VC_W-1:0]   grant_vc,
    output logic              req_stall
);

    logic [VC_W-1:0]  tbl_vc;
    logic [CNT_W-1:0] tbl_cnt;
    logic             pick_valid;
    logic [VC_W-1:0]  pick_vc;
    logic             use_table;
    logic             fresh;

    vcx_flow_table #(
        .NUM_FLOWS (NUM_FLOWS),
        .NUM_VC    (NUM_VC),
        .VC_DEPTH  (VC_DEPTH)
    ) table_i (
        .clk      (clk),
        .rst      (rst),
        .rd_flow  (req_flow),
        .rd_vc    (tbl_vc),
        .rd_cnt   (tbl_cnt),
        .inc_en   (grant_valid),
        .inc_flow (req_flow),
        .bind_en  (fresh),
        .bind_vc  (pick_vc),
        .dec_en   (cred_valid),
        .dec_flow (cred_flow)
    );

    vcx_rr_pick #(
        .NUM_VC (NUM_VC)
    ) pick_i (
        .clk        (clk),
        .rst        (rst),
        .avail      (vc_avail),
        .advance    (fresh),
        .pick_valid (pick_valid),
        .pick_vc    (pick_vc)
    );

    // The table entry wins over the free pick for continuation flits
    // and for any flow that still has flits downstream.
    assign use_table = !req_head || (tbl_cnt != '0);

    always_comb begin
        grant_vc    = use_table ? tbl_vc : pick_vc;
        grant_valid = req_valid && (use_table ? vc_avail[tbl_vc] : pick_valid);
        req_stall   = req_valid && !grant_valid;
        fresh       = grant_valid && !use_table;
    end

    // R9: a grant only ever names an available VC
    assert_grant_avail_R9: assert property (@(posedge clk) disable iff (rst)
        grant_valid |-> vc_avail[grant_vc]);

    // R9: grant and stall are exclusive, and both are low without a request
    assert_resp_excl_R9: assert property (@(posedge clk) disable iff (rst)
        !(grant_valid && req_stall) && (req_valid || (!grant_valid && !req_stall)));

    // R5: a flow with flits downstream is never given a different VC
    assert_pinned_R5: assert property (@(posedge clk) disable iff (rst)
        (grant_valid && tbl_cnt != '0) |-> grant_vc == tbl_vc);

    // R2: a fresh binding takes the pointer's pick
    assert_fresh_pick_R2: assert property (@(posedge clk) disable iff (rst)
        fresh |-> (pick_valid && grant_vc == pick_vc));

endmodule

// File: tb/vcx_alloc_top_tb_top.sv
`timescale 1ns/1ps
module vcx_alloc_top_tb_top;

    logic       clk = 1'b0;
    logic       rst;
    logic       req_valid;
    logic       req_head;
    logic [3:0] req_flow;
    logic [3:0] vc_avail;
    logic       cred_valid;
    logic [3:0] cred_flow;
    logic       grant_valid;
    logic [1:0] grant_vc;
    logic       req_stall;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    vcx_alloc_top dut_i (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_head    (req_head),
        .req_flow    (req_flow),
        .vc_avail    (vc_avail),
        .cred_valid  (cred_valid),
        .cred_flow   (cred_flow),
        .grant_valid (grant_valid),
        .grant_vc    (grant_vc),
        .req_stall   (req_stall)
    );

    typedef struct packed {
        logic       rv;
        logic       hd;
        logic [3:0] fl;
        logic [3:0] av;
        logic       cv;
        logic [3:0] cf;
        logic       eg;
        logic [1:0] evc;
        logic       es;
        logic [3:0] rq;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{1'b0,1'b0,4'd0,4'b1111,1'b0,4'd0,1'b0,2'd0,1'b0,4'd9},  // R9 idle
        '{1'b1,1'b1,4'd1,4'b1111,1'b0,4'd0,1'b1,2'd0,1'b0,4'd1},  // R1 first pick VC0
        '{1'b1,1'b1,4'd2,4'b1111,1'b0,4'd0,1'b1,2'd1,1'b0,4'd2},  // R2 pointer moved
        '{1'b1,1'b1,4'd1,4'b1111,1'b0,4'd0,1'b1,2'd0,1'b0,4'd4},  // R4 pinned to VC0
        '{1'b1,1'b1,4'd1,4'b1110,1'b0,4'd0,1'b0,2'd0,1'b1,4'd5},  // R5 own VC busy
        '{1'b1,1'b1,4'd3,4'b0000,1'b0,4'd0,1'b0,2'd0,1'b1,4'd3},  // R3 none available
        '{1'b1,1'b1,4'd3,4'b1000,1'b0,4'd0,1'b1,2'd3,1'b0,4'd2},  // R2 skip to VC3
        '{1'b1,1'b1,4'd4,4'b0010,1'b0,4'd0,1'b1,2'd1,1'b0,4'd2},  // R2 wrap to VC1
        '{1'b0,1'b0,4'd0,4'b1111,1'b1,4'd1,1'b0,2'd0,1'b0,4'd7},  // R7 credit flow1
        '{1'b1,1'b1,4'd1,4'b1111,1'b1,4'd1,1'b1,2'd0,1'b0,4'd8},  // R8 grant+credit
        '{1'b0,1'b0,4'd0,4'b1111,1'b1,4'd1,1'b0,2'd0,1'b0,4'd7},  // R7 drain flow1
        '{1'b1,1'b1,4'd1,4'b1111,1'b0,4'd0,1'b1,2'd2,1'b0,4'd7},  // R7 rebind VC2
        '{1'b1,1'b0,4'd1,4'b0100,1'b0,4'd0,1'b1,2'd2,1'b0,4'd6},  // R6 body on VC2
        '{1'b1,1'b0,4'd1,4'b1011,1'b0,4'd0,1'b0,2'd0,1'b1,4'd6},  // R6 body stalls
        '{1'b1,1'b1,4'd4,4'b1111,1'b1,4'd2,1'b1,2'd1,1'b0,4'd11}, // R11 flow4 kept
        '{1'b1,1'b1,4'd2,4'b1111,1'b0,4'd0,1'b1,2'd3,1'b0,4'd7},  // R7 flow2 rebinds
        '{1'b1,1'b0,4'd2,4'b1111,1'b0,4'd0,1'b1,2'd3,1'b0,4'd6}   // R6 body follows
    };

    task automatic drive(input logic rv, input logic hd, input logic [3:0] fl,
                         input logic [3:0] av, input logic cv, input logic [3:0] cf);
        @(negedge clk);
        req_valid  = rv;
        req_head   = hd;
        req_flow   = fl;
        vc_avail   = av;
        cred_valid = cv;
        cred_flow  = cf;
        #1;
    endtask

    task automatic check(input logic eg, input logic [1:0] evc, input logic es,
                         input int rq);
        n_cmp++;
        if (grant_valid !== eg || req_stall !== es || (eg && grant_vc !== evc)) begin
            n_bad++;
            $display("FAIL R%0d: grant=%0b vc=%0d stall=%0b, expected grant=%0b vc=%0d stall=%0b",
                     rq, grant_valid, grant_vc, req_stall, eg, evc, es);
        end
    endtask

    initial begin
        rst = 1'b1;
        req_valid = 1'b0; req_head = 1'b0; req_flow = '0;
        vc_avail = '0; cred_valid = 1'b0; cred_flow = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // R1: reset state, no request gives no response
        drive(1'b0, 1'b0, 4'd0, 4'b1111, 1'b0, 4'd0);
        check(1'b0, 2'd0, 1'b0, 1);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].rv, VECS[i].hd, VECS[i].fl, VECS[i].av, VECS[i].cv, VECS[i].cf);
            check(VECS[i].eg, VECS[i].evc, VECS[i].es, int'(VECS[i].rq));
        end

        // R1: reset clears bindings and the pointer
        @(negedge clk) rst = 1'b1;
        req_valid = 1'b0; cred_valid = 1'b0;
        @(negedge clk) rst = 1'b0;
        drive(1'b1, 1'b1, 4'd1, 4'b1111, 1'b0, 4'd0);
        check(1'b1, 2'd0, 1'b0, 1);

        // R6: body flit of a never-used flow follows stored VC 0
        drive(1'b1, 1'b0, 4'd9, 4'b0001, 1'b0, 4'd0);
        check(1'b1, 2'd0, 1'b0, 6);
        drive(1'b1, 1'b0, 4'd9, 4'b1110, 1'b0, 4'd0);
        check(1'b0, 2'd0, 1'b1, 6);

        // R10: fill flow5 to exactly the depth (8) on VC1, then VC1 goes busy
        drive(1'b1, 1'b1, 4'd5, 4'b1111, 1'b0, 4'd0);
        check(1'b1, 2'd1, 1'b0, 2);
        for (int k = 0; k < 7; k++) begin
            drive(1'b1, 1'b0, 4'd5, 4'b1111, 1'b0, 4'd0);
            check(1'b1, 2'd1, 1'b0, 10);
        end
        drive(1'b1, 1'b1, 4'd5, 4'b1101, 1'b0, 4'd0);
        check(1'b0, 2'd0, 1'b1, 5);

        // R4: a credit leaves 7 outstanding, so the next head still goes to VC1
        drive(1'b0, 1'b0, 4'd0, 4'b1101, 1'b1, 4'd5);
        check(1'b0, 2'd0, 1'b0, 11);
        drive(1'b1, 1'b1, 4'd5, 4'b1111, 1'b0, 4'd0);
        check(1'b1, 2'd1, 1'b0, 4);

        drive(1'b0, 1'b0, 4'd0, 4'b0000, 1'b0, 4'd0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule